// File: doc/BRIEF.md
# Checksummed SPI Register-Write Target

This block is an SPI target that accepts fixed eight-byte host command frames and turns valid ones into 32-bit writes into a small internal register file. The SPI pins are oversampled by a system clock that runs at least eight times faster than the serial clock. Each frame is delimited by one low period of the active-low chip select. The frame layout is: a command byte, a 16-bit register address sent low byte first, a 32-bit data word sent most significant byte first, and a trailing additive checksum. Only a frame that carries the write command, a matching checksum and an in-range address changes the register file. The rest of the chip reads the register contents from a flat output bus.

Three single-cycle status pulses report the result of every chip-select period. `frame_ok` marks an executed write. `frame_bad` marks a complete frame that was refused. `frame_cut` marks a frame that ended early. Read commands are not decoded, so MISO always returns all ones.

A four-state machine controls the receiver:
- `ST_IDLE` waits for a falling edge on chip select and moves to `ST_RECV`.
- `ST_RECV` collects bytes. It moves to `ST_CHECK` when the eighth byte completes, or falls back to `ST_IDLE` with a framing-error pulse if chip select rises first.
- `ST_CHECK` lasts one cycle. It judges the frame, issues the write or the rejection, and moves to `ST_DRAIN`.
- `ST_DRAIN` ignores all further serial clocks and returns to `ST_IDLE` once chip select is high.

Top module: `spi_cmd_target`

## Requirements
- R1: Serial data is sampled on rising SCLK edges with SCLK idling low (SPI mode 0), most significant bit first within each byte.
- R2: A frame is eight bytes in this order: command, address bits 7:0, address bits 15:8, data bits 31:24, data bits 23:16, data bits 15:8, data bits 7:0, checksum. When the frame is accepted, register `addr` is written with the data. Register i is visible on `regs_flat[32*i+31:32*i]`.
- R3: If the checksum byte differs from the modulo-256 sum of the seven preceding bytes, the frame writes nothing and `frame_bad` pulses. For example, 00 20 00 10 00 00 00 30 is a valid frame that writes 0x10000000 to register 0x20.
- R4: A command byte other than 0x00, the write command, causes no write and a `frame_bad` pulse, even when the checksum is correct.
- R5: An address of REG_COUNT or more (default 64) causes no write and a `frame_bad` pulse.
- R6: An executed write produces exactly one single-cycle `frame_ok` pulse. At most one of `frame_ok`, `frame_bad` and `frame_cut` is high in any cycle.
- R7: If chip select rises after fewer than 64 bits, including after zero bits, the partial frame is discarded, `frame_cut` pulses once, and the next frame starts from byte zero.
- R8: While chip select stays low, bits after the 64th are ignored, even if they form a valid frame. A new frame starts only after chip select rises and falls again.
- R9: `spi_miso` is driven high at all times.
- R10: After reset all registers read zero and no status pulse is high.
- R11: The register file changes only in the cycle that follows a `frame_ok` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x SCLK |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host, constant one |
| frame_ok | output | 1 | Pulse: write executed |
| frame_bad | output | 1 | Pulse: complete frame refused (checksum, command or address) |
| frame_cut | output | 1 | Pulse: chip select rose before 64 bits |
| regs_flat | output | REG_COUNT*32 | All register contents, register i in bits 32*i+31:32*i |

## Verification
The bench compares `regs_flat` and the counts of the three status pulses against a model after every frame. A wrong bit counter or byte index shows as data written to the wrong register, or as a bad or cut pulse in place of ok, within about six system cycles of the last SCLK edge. A wrong checksum accumulator flips good frames to `frame_bad`, or lets corrupted frames through, at the end of the same frame. A state machine stuck in `ST_DRAIN` or `ST_RECV` leaves the next frame without any status pulse.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_CHECK,
        ST_DRAIN
    } rx_state_t;

    localparam int          BYTE_W      = 8;
    localparam int          FRAME_BYTES = 8;
    localparam int          ADDR_W      = 16;
    localparam int          DATA_W      = 32;
    localparam logic [7:0]  CMD_WRITE   = 8'h00;
endpackage

// File: rtl/spi_cmd_sync.sv
`timescale 1ns/1ps
module spi_cmd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic cs_n_i,
    input  logic mosi_i,
    output logic sclk_rise_o,
    output logic cs_fall_o,
    output logic cs_rise_o,
    output logic cs_low_o,
    output logic mosi_o
);
    // bit 0: sclk, bit 1: cs_n, bit 2: mosi
    logic [2:0] chain [STAGES];
    logic [1:0] last_q;
    logic [2:0] cur;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= 3'b010;
            last_q <= 2'b10;
        end else begin
            chain[0] <= {mosi_i, cs_n_i, sclk_i};
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
            last_q <= chain[STAGES-1][1:0];
        end
    end

    assign cur         = chain[STAGES-1];
    assign sclk_rise_o = cur[0] & ~last_q[0];
    assign cs_fall_o   = ~cur[1] & last_q[1];
    assign cs_rise_o   = cur[1] & ~last_q[1];
    assign cs_low_o    = ~cur[1];
    assign mosi_o      = cur[2];
endmodule

// File: rtl/spi_cmd_shifter.sv
`timescale 1ns/1ps
module spi_cmd_shifter
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active_i,
    input  logic              bit_stb_i,
    input  logic              bit_i,
    output logic              byte_vld_o,
    output logic [BYTE_W-1:0] byte_o
);
    localparam int CNT_W = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sh_q;
    logic [CNT_W-1:0]  cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q       <= '0;
            cnt_q      <= '0;
            byte_vld_o <= 1'b0;
        end else begin
            byte_vld_o <= 1'b0;
            if (!active_i) begin
                cnt_q <= '0;
            end else if (bit_stb_i) begin
                sh_q       <= {sh_q[BYTE_W-2:0], bit_i};
                cnt_q      <= cnt_q + 1'b1;
                byte_vld_o <= (cnt_q == CNT_W'(BYTE_W - 1));
            end
        end
    end

    assign byte_o = sh_q;
endmodule

// File: rtl/spi_cmd_fsm.sv
`timescale 1ns/1ps
module spi_cmd_fsm
    import spi_cmd_pkg::*;
#(
    parameter int REG_COUNT = 64,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_fall_i,
    input  logic              cs_rise_i,
    input  logic              cs_low_i,
    input  logic              byte_vld_i,
    input  logic [BYTE_W-1:0] byte_i,
    output logic              recv_o,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              ok_o,
    output logic              bad_o,
    output logic              cut_o
);
    localparam int BIDX_W = $clog2(FRAME_BYTES);
    localparam logic [BIDX_W-1:0] LAST_IDX = BIDX_W'(FRAME_BYTES - 1);

    rx_state_t          state_q, state_d;
    logic [BIDX_W-1:0]  bidx_q;
    logic [BYTE_W-1:0]  cmd_q, sum_q, chk_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [DATA_W-1:0]  data_q;
    logic               last_byte, good;

    assign last_byte = byte_vld_i && (bidx_q == LAST_IDX);
    assign good      = (chk_q == sum_q) && (cmd_q == CMD_WRITE) &&
                       (int'(addr_q) < REG_COUNT);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cs_fall_i) state_d = ST_RECV;
            ST_RECV:  begin
                if (last_byte)      state_d = ST_CHECK;
                else if (cs_rise_i) state_d = ST_IDLE;
            end
            ST_CHECK: state_d = ST_DRAIN;
            ST_DRAIN: if (!cs_low_i) state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        recv_o  = (state_q == ST_RECV);
        wr_en_o = 1'b0;
        ok_o    = 1'b0;
        bad_o   = 1'b0;
        cut_o   = 1'b0;
        unique case (state_q)
            ST_CHECK: begin
                wr_en_o = good;
                ok_o    = good;
                bad_o   = !good;
            end
            ST_RECV:  cut_o = cs_rise_i && !last_byte;
            default:  ;
        endcase
    end

    assign wr_idx_o  = addr_q[IDX_W-1:0];
    assign wr_data_o = data_q;

    // frame datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bidx_q <= '0;
            cmd_q  <= '0;
            sum_q  <= '0;
            chk_q  <= '0;
            addr_q <= '0;
            data_q <= '0;
        end else if (state_q == ST_IDLE && cs_fall_i) begin
            bidx_q <= '0;
            sum_q  <= '0;
        end else if (state_q == ST_RECV && byte_vld_i) begin
            bidx_q <= bidx_q + 1'b1;
            if (bidx_q == LAST_IDX) begin
                chk_q <= byte_i;
            end else begin
                sum_q <= sum_q + byte_i;
                unique case (bidx_q)
                    BIDX_W'(0): cmd_q <= byte_i;
                    BIDX_W'(1): addr_q[7:0]  <= byte_i;
                    BIDX_W'(2): addr_q[15:8] <= byte_i;
                    default:    data_q <= {data_q[DATA_W-BYTE_W-1:0], byte_i};
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int REG_COUNT = 64,
    localparam int IDX_W    = $clog2(REG_COUNT)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en_i,
    input  logic [IDX_W-1:0]            wr_idx_i,
    input  logic [DATA_W-1:0]           wr_data_i,
    output logic [REG_COUNT*DATA_W-1:0] regs_o
);
    logic [DATA_W-1:0] mem_q [REG_COUNT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < REG_COUNT; i++) mem_q[i] <= '0;
        end else if (wr_en_i) begin
            mem_q[wr_idx_i] <= wr_data_i;
        end
    end

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_flat
        assign regs_o[g*DATA_W +: DATA_W] = mem_q[g];
    end
endmodule

// File: rtl/spi_cmd_target.sv
`timescale 1ns/1ps
module spi_cmd_target
    import spi_cmd_pkg::*;
#(
    parameter int REG_COUNT   = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        spi_sclk,
    input  logic                        spi_cs_n,
    input  logic                        spi_mosi,
    output logic                        spi_miso,
    output logic                        frame_ok,
    output logic                        frame_bad,
    output logic                        frame_cut,
    output logic [REG_COUNT*DATA_W-1:0] regs_flat
);
    localparam int IDX_W = $clog2(REG_COUNT);

    logic              sclk_rise, cs_fall, cs_rise, cs_low, mosi_s;
    logic              recv, byte_vld, wr_en;
    logic [BYTE_W-1:0] rx_byte;
    logic [IDX_W-1:0]  wr_idx;
    logic [DATA_W-1:0] wr_data;

    spi_cmd_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .sclk_i      (spi_sclk),
        .cs_n_i      (spi_cs_n),
        .mosi_i      (spi_mosi),
        .sclk_rise_o (sclk_rise),
        .cs_fall_o   (cs_fall),
        .cs_rise_o   (cs_rise),
        .cs_low_o    (cs_low),
        .mosi_o      (mosi_s)
    );

    spi_cmd_shifter i_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (recv),
        .bit_stb_i  (sclk_rise),
        .bit_i      (mosi_s),
        .byte_vld_o (byte_vld),
        .byte_o     (rx_byte)
    );

    spi_cmd_fsm #(.REG_COUNT(REG_COUNT)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_fall_i  (cs_fall),
        .cs_rise_i  (cs_rise),
        .cs_low_i   (cs_low),
        .byte_vld_i (byte_vld),
        .byte_i     (rx_byte),
        .recv_o     (recv),
        .wr_en_o    (wr_en),
        .wr_idx_o   (wr_idx),
        .wr_data_o  (wr_data),
        .ok_o       (frame_ok),
        .bad_o      (frame_bad),
        .cut_o      (frame_cut)
    );

    spi_cmd_regs #(.REG_COUNT(REG_COUNT)) i_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .regs_o    (regs_flat)
    );

    assign spi_miso = 1'b1;
endmodule

// File: rtl/spi_cmd_chk.sv
`timescale 1ns/1ps
module spi_cmd_chk #(
    parameter int REG_COUNT = 64
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   spi_miso,
    input logic                   frame_ok,
    input logic                   frame_bad,
    input logic                   frame_cut,
    input logic [REG_COUNT*32-1:0] regs_flat
);
    // R6
    status_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({frame_ok, frame_bad, frame_cut}));

    // R6
    ok_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_ok |=> !frame_ok);

    // R3
    bad_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        frame_bad |=> !frame_bad);

    // R9
    miso_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        spi_miso == 1'b1);

    // R11
    regs_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_ok |=> $stable(regs_flat));
endmodule

bind spi_cmd_target spi_cmd_chk #(.REG_COUNT(REG_COUNT)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_miso  (spi_miso),
    .frame_ok  (frame_ok),
    .frame_bad (frame_bad),
    .frame_cut (frame_cut),
    .regs_flat (regs_flat)
);

// File: tb/test_spi_cmd_target.sv
`timescale 1ns/1ps
module test_spi_cmd_target;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 5;
    localparam int REGS       = 64;
    localparam int WATCHDOG   = 190000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic spi_sclk = 1'b0;
    logic spi_cs_n = 1'b1;
    logic spi_mosi = 1'b0;
    logic spi_miso, frame_ok, frame_bad, frame_cut;
    logic [REGS*32-1:0] regs_flat;

    int n_chk = 0, n_fail = 0;
    int n_ok = 0, n_bad = 0, n_cut = 0, n_miso_low = 0;
    logic [31:0] model [REGS];
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_cmd_target #(.REG_COUNT(REGS)) i_spi_cmd_target (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_sclk  (spi_sclk),
        .spi_cs_n  (spi_cs_n),
        .spi_mosi  (spi_mosi),
        .spi_miso  (spi_miso),
        .frame_ok  (frame_ok),
        .frame_bad (frame_bad),
        .frame_cut (frame_cut),
        .regs_flat (regs_flat)
    );

    always @(posedge clk) begin
        if (rst_n) begin
            if (frame_ok)  n_ok++;
            if (frame_bad) n_bad++;
            if (frame_cut) n_cut++;
            if (spi_miso !== 1'b1) n_miso_low++;
        end
    end

    task automatic check(input bit cond, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_frame(input logic [7:0] cmd, input logic [15:0] addr,
                                             input logic [31:0] data, input logic [7:0] flip);
        logic [7:0] s;
        s = cmd + addr[7:0] + addr[15:8] + data[31:24] + data[23:16] + data[15:8] + data[7:0];
        return {cmd, addr[7:0], addr[15:8], data, s ^ flip};
    endfunction

    task automatic check_regs(input string req);
        int bad_i = -1;
        for (int i = 0; i < REGS; i++)
            if (bad_i < 0 && regs_flat[i*32 +: 32] !== model[i]) bad_i = i;
        if (bad_i < 0) check(1'b1, req, "registers", 0, 0);
        else check(1'b0, req, $sformatf("register %0d", bad_i),
                   {32'h0, regs_flat[bad_i*32 +: 32]}, {32'h0, model[bad_i]});
    endtask

    // R1: drive mode 0, MSB first; extra bits past 64 come from tail
    task automatic send_bits(input logic [63:0] fr, input logic [63:0] tail, input int nbits);
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            spi_mosi = (b < 64) ? fr[63-b] : tail[127-b];
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (20) @(negedge clk);
    endtask

    task automatic run_frame(input logic [63:0] fr, input logic [63:0] tail,
                             input int nbits, input string req);
        int ok0 = n_ok, bad0 = n_bad, cut0 = n_cut, miso0 = n_miso_low;
        logic [7:0] cmd, chk, s;
        logic [15:0] addr;
        logic [31:0] data;
        int e_ok = 0, e_bad = 0, e_cut = 0;
        cmd  = fr[63:56];
        addr = {fr[47:40], fr[55:48]};
        data = fr[39:8];
        chk  = fr[7:0];
        s    = fr[63:56] + fr[55:48] + fr[47:40] + fr[39:32] + fr[31:24] + fr[23:16] + fr[15:8];
        if (nbits < 64) e_cut = 1;
        else if (chk == s && cmd == 8'h00 && addr < 16'(REGS)) begin
            e_ok = 1;
            model[addr[5:0]] = data;
        end else e_bad = 1;
        send_bits(fr, tail, nbits);
        check(n_ok - ok0 == e_ok,   req, "frame_ok pulses",  n_ok - ok0,   e_ok);
        check(n_bad - bad0 == e_bad, req, "frame_bad pulses", n_bad - bad0, e_bad);
        check(n_cut - cut0 == e_cut, req, "frame_cut pulses", n_cut - cut0, e_cut);
        check(n_miso_low == miso0, "R9", "miso low cycles", n_miso_low - miso0, 0);
        check_regs(req);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < REGS; i++) model[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R10: reset state
        check_regs("R10");
        check({frame_ok, frame_bad, frame_cut} == 3'b000, "R10", "status after reset",
              {frame_ok, frame_bad, frame_cut}, 0);
        check(spi_miso === 1'b1, "R9", "miso after reset", spi_miso, 1);

        // R2 R3: worked example, data MSB byte first, little-endian address
        run_frame(64'h0020001000000030, 64'h0, 64, "R2");
        check(regs_flat[32*32 +: 32] == 32'h10000000, "R2", "reg 0x20 value",
              regs_flat[32*32 +: 32], 32'h10000000);
        // R2: address low byte first, distinct data bytes
        run_frame(mk_frame(8'h00, 16'h0005, 32'hA1B2C3D4, 8'h00), 64'h0, 64, "R2");
        run_frame(mk_frame(8'h00, 16'h003F, 32'hFFFFFFFF, 8'h00), 64'h0, 64, "R2");
        // R3: checksum mismatch
        run_frame(mk_frame(8'h00, 16'h0005, 32'h11111111, 8'h01), 64'h0, 64, "R3");
        run_frame(mk_frame(8'h00, 16'h0006, 32'h22222222, 8'h80), 64'h0, 64, "R3");
        // R4: unknown command with correct checksum
        run_frame(mk_frame(8'h05, 16'h0007, 32'h33333333, 8'h00), 64'h0, 64, "R4");
        run_frame(mk_frame(8'hFF, 16'h0007, 32'h44444444, 8'h00), 64'h0, 64, "R4");
        // R5: address out of range (low byte and high byte)
        run_frame(mk_frame(8'h00, 16'h0040, 32'h55555555, 8'h00), 64'h0, 64, "R5");
        run_frame(mk_frame(8'h00, 16'h0100, 32'h66666666, 8'h00), 64'h0, 64, "R5");
        // R7: early chip-select release, zero bits, then clean frame
        run_frame(mk_frame(8'h00, 16'h0009, 32'h77777777, 8'h00), 64'h0, 40, "R7");
        run_frame(mk_frame(8'h00, 16'h0009, 32'h77777777, 8'h00), 64'h0, 0, "R7");
        run_frame(mk_frame(8'h00, 16'h0009, 32'h77777777, 8'h00), 64'h0, 63, "R7");
        run_frame(mk_frame(8'h00, 16'h000A, 32'h88888888, 8'h00), 64'h0, 64, "R7");
        // R8: trailing bits form a valid frame to another register; ignored
        run_frame(mk_frame(8'h00, 16'h000B, 32'h99999999, 8'h00),
                  mk_frame(8'h00, 16'h000C, 32'hCAFEF00D, 8'h00), 128, "R8");
        run_frame(mk_frame(8'h00, 16'h000D, 32'h12345678, 8'h00),
                  64'hFFFFFFFFFFFFFFFF, 80, "R8");

        // R1 R6: constrained random frames
        for (int k = 0; k < 60; k++) begin
            logic [7:0] cmd, flip;
            logic [15:0] addr;
            logic [31:0] data;
            int nb;
            cmd  = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
            addr = ($urandom % 8 == 0) ? 16'($urandom) : 16'($urandom % REGS);
            data = $urandom;
            flip = ($urandom % 5 == 0) ? 8'(1 + $urandom % 255) : 8'h00;
            nb   = ($urandom % 10 == 0) ? int'($urandom % 64) : 64;
            run_frame(mk_frame(cmd, addr, data, flip), 64'h0, nb, "R6");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule